// File: doc/BRIEF.md
# Queued I2C Controller Register Front-End

This block is the register file that sits between a 32-bit memory-mapped bus and an I2C command engine. Software loads command words into a command queue. The engine may take a command only while a run bit is set. Transmit bytes arrive packed four to a 32-bit word and are handed to the engine one byte at a time, first byte from the least significant lane. Received bytes collect in a read queue that software drains one byte per read. Interrupt status bits are set by engine events, masked by enable bits and ORed into a single interrupt line.

The control, interrupt and queue-control registers have set and clear aliases, so software can change single bits without a read-modify-write sequence. A soft-reset bit brings every register and queue back to its idle state. The serial bit timing belongs to the engine. Here the engine appears only as ready/valid handshakes and an event vector.

Top module: `i2cq_regs`

## Requirements
- R1: After reset, reads at 0x00, 0x40 and 0x60 return 0. A read at 0x70 returns 0x0000_2000. irqOut, cmdValid, txValid and pioMode are all 0.
- R2: The interrupt register at 0x40 holds status in bits 7:0 and enables in bits 15:8; bits 31:16 read as 0. A write at 0x40 loads the register. A write at 0x44 ORs the value in. A write at 0x48 clears every bit written as 1.
- R3: irqOut is the OR over i of (status[i] AND enable[i]). It is updated one clock after the register or event changes. Each irqEvt bit sets its status bit and the status bit stays set. An event wins over a clear of the same bit in the same cycle.
- R4: The queue-control register (0x60 load, 0x64 set, 0x68 clear) keeps only bit 5 (run) and bit 2 (pioMode output). cmdValid is high only while run is 1 and the command queue is not empty, so clearing run stops command hand-off.
- R5: A write at 0x80 pushes a command word. The engine receives commands in write order on cmdWord, and each cmdValid/cmdReady handshake takes one. Bits 4:0 of the status word at 0x70 give the number of waiting commands. The queue holds 16 commands, and a push to a full queue is dropped.
- R6: A word written at 0xA0 is sent as bytes in the order bits 7:0, 15:8, 23:16, 31:24. Each txValid/txReady handshake takes one byte.
- R7: Each accepted command with bit 16 set adds its bits 15:0 to a transmit byte budget. A data word yields min(4, budget) bytes, lowest lanes first, and uses up that many. A word that arrives with a budget of 0 is dropped.
- R8: A read at 0x90 returns the oldest received byte in bits 7:0 and removes it from the queue. Bit 13 at 0x70 is 1 while the receive queue is empty. A read of an empty queue returns 0. Each rxValid cycle stores rxByte.
- R9: A write with bit 31 set at 0x00 or 0x04 empties all queues, clears the byte budget, and clears the control, interrupt and queue-control registers.
- R10: A write at 0x00 loads bits 30:0 of the control register and a write at 0x04 ORs them in. Bit 31 always reads as 0.
- R11: busRdata is registered: it takes the value selected by a read on the clock edge that ends the busRdEn cycle, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| cmdValid | output | 1 | Command available to the engine |
| cmdWord | output | 32 | Oldest queued command |
| cmdReady | input | 1 | Engine takes the command |
| txValid | output | 1 | Transmit byte available |
| txByte | output | 8 | Next transmit byte |
| txReady | input | 1 | Engine takes the byte |
| rxValid | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| irqEvt | input | 8 | Engine event pulses, one per status bit |
| irqOut | output | 1 | Combined interrupt |
| pioMode | output | 1 | Queue mode bit to the engine |

## Verification
A bus write takes effect at the clock edge that ends its cycle. A read returns its value at the edge after the read is issued. The engine-side outputs (cmdValid, txValid, irqOut) follow one edge after the write or event that changes them. The bench drives on falling edges and samples on the next falling edge, half a period after the edge that updates the result. The registered read path is also checked inside the read cycle, where busRdata must still show the previous value. Random interrupt-register sequences and random transmit byte budgets are compared against bench models. Directed cases cover a full command queue, transmit words that find no budget, and clears that collide with events.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam logic [7:0] ADDR_CFG      = 8'h00;
  localparam logic [7:0] ADDR_CFG_SET  = 8'h04;
  localparam logic [7:0] ADDR_IRQ      = 8'h40;
  localparam logic [7:0] ADDR_IRQ_SET  = 8'h44;
  localparam logic [7:0] ADDR_IRQ_CLR  = 8'h48;
  localparam logic [7:0] ADDR_QCTL     = 8'h60;
  localparam logic [7:0] ADDR_QCTL_SET = 8'h64;
  localparam logic [7:0] ADDR_QCTL_CLR = 8'h68;
  localparam logic [7:0] ADDR_QSTAT    = 8'h70;
  localparam logic [7:0] ADDR_CMDQ     = 8'h80;
  localparam logic [7:0] ADDR_RXQ      = 8'h90;
  localparam logic [7:0] ADDR_TXQ      = 8'hA0;

  localparam int RUN_BIT     = 5;
  localparam int PIO_BIT     = 2;
  localparam int SRST_BIT    = 31;
  localparam int RXEMPTY_BIT = 13;
  localparam int DIR_BIT     = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CFG, SEL_IRQ, SEL_QCTL, SEL_QSTAT, SEL_RX
  } rdsel_t;

  typedef struct packed {
    logic   cfgLoad;
    logic   cfgSet;
    logic   irqLoad;
    logic   irqSet;
    logic   irqClr;
    logic   qLoad;
    logic   qSet;
    logic   qClr;
    logic   cmdPush;
    logic   txPush;
    logic   rxPop;
    logic   softRst;
    logic   rdEn;
    rdsel_t rdSel;
  } strobe_t;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rdPtr, wrPtr;
  logic             doPush, doPop;

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !clr) |=> (count == $past(count)));
endmodule

// File: rtl/i2cq_ctrl.sv
module i2cq_ctrl
  import i2cq_pkg::*;
(
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [7:0] busAddr,
  input  logic       srstBit,
  output strobe_t    stb
);
  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_NONE;
    stb.rdEn  = busRdEn;
    if (busWrEn) begin
      unique case (busAddr)
        ADDR_CFG:      begin stb.cfgLoad = 1'b1; stb.softRst = srstBit; end
        ADDR_CFG_SET:  begin stb.cfgSet  = 1'b1; stb.softRst = srstBit; end
        ADDR_IRQ:      stb.irqLoad = 1'b1;
        ADDR_IRQ_SET:  stb.irqSet  = 1'b1;
        ADDR_IRQ_CLR:  stb.irqClr  = 1'b1;
        ADDR_QCTL:     stb.qLoad   = 1'b1;
        ADDR_QCTL_SET: stb.qSet    = 1'b1;
        ADDR_QCTL_CLR: stb.qClr    = 1'b1;
        ADDR_CMDQ:     stb.cmdPush = 1'b1;
        ADDR_TXQ:      stb.txPush  = 1'b1;
        default: ;
      endcase
    end
    if (busRdEn) begin
      unique case (busAddr)
        ADDR_CFG, ADDR_CFG_SET:                 stb.rdSel = SEL_CFG;
        ADDR_IRQ, ADDR_IRQ_SET, ADDR_IRQ_CLR:   stb.rdSel = SEL_IRQ;
        ADDR_QCTL, ADDR_QCTL_SET, ADDR_QCTL_CLR: stb.rdSel = SEL_QCTL;
        ADDR_QSTAT:                             stb.rdSel = SEL_QSTAT;
        ADDR_RXQ: begin
          stb.rdSel = SEL_RX;
          stb.rxPop = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cq_datapath.sv
module i2cq_datapath
  import i2cq_pkg::*;
#(
  parameter int CMD_DEPTH = 16,
  parameter int TX_DEPTH  = 8,
  parameter int RX_DEPTH  = 8,
  parameter int BUDGET_W  = 20,
  localparam int CCW = $clog2(CMD_DEPTH + 1),
  localparam int TCW = $clog2(TX_DEPTH + 1),
  localparam int RCW = $clog2(RX_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        cmdValid,
  output logic [31:0] cmdWord,
  input  logic        cmdReady,
  output logic        txValid,
  output logic [7:0]  txByte,
  input  logic        txReady,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic [7:0]  irqEvt,
  output logic        irqOut,
  output logic        pioMode
);
  logic [30:0]         cfgReg;
  logic [7:0]          irqStat, irqEn, statNext, enNext;
  logic                runBit, pioBit, runNext, pioNext;
  logic [BUDGET_W-1:0] budget;
  logic [1:0]          lane;

  // interrupt register: set/clear aliases, events win over clears
  always_comb begin
    statNext = irqStat;
    enNext   = irqEn;
    if (stb.irqLoad) {enNext, statNext} = busWdata[15:0];
    if (stb.irqSet)  {enNext, statNext} = {enNext, statNext} | busWdata[15:0];
    if (stb.irqClr)  {enNext, statNext} = {enNext, statNext} & ~busWdata[15:0];
    statNext = statNext | irqEvt;
  end

  always_comb begin
    runNext = runBit;
    pioNext = pioBit;
    if (stb.qLoad) begin runNext = busWdata[RUN_BIT]; pioNext = busWdata[PIO_BIT]; end
    if (stb.qSet)  begin runNext |= busWdata[RUN_BIT]; pioNext |= busWdata[PIO_BIT]; end
    if (stb.qClr)  begin
      runNext &= ~busWdata[RUN_BIT];
      pioNext &= ~busWdata[PIO_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0; irqStat <= '0; irqEn <= '0; runBit <= 1'b0; pioBit <= 1'b0;
    end else if (stb.softRst) begin
      cfgReg <= '0; irqStat <= '0; irqEn <= '0; runBit <= 1'b0; pioBit <= 1'b0;
    end else begin
      if (stb.cfgLoad)     cfgReg <= busWdata[30:0];
      else if (stb.cfgSet) cfgReg <= cfgReg | busWdata[30:0];
      irqStat <= statNext;
      irqEn   <= enNext;
      runBit  <= runNext;
      pioBit  <= pioNext;
    end
  end

  assign irqOut  = |(irqStat & irqEn);
  assign pioMode = pioBit;

  // command queue, gated by the run bit
  logic           cmdFull, cmdEmpty;
  logic [CCW-1:0] cmdCount;
  assign cmdValid = runBit && !cmdEmpty;

  i2cq_fifo #(.WIDTH(32), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk, .rstN, .clr(stb.softRst),
    .push(stb.cmdPush), .din(busWdata), .pop(cmdValid && cmdReady),
    .dout(cmdWord), .full(cmdFull), .empty(cmdEmpty), .count(cmdCount)
  );

  // transmit byte budget and word queue
  logic [15:0] addBytes;
  logic [2:0]  take;
  logic        txFull, txEmpty, txAccept, txPopW, lastLane;
  logic [33:0] txHead;
  logic [TCW-1:0] txCount;

  assign addBytes = (stb.cmdPush && !cmdFull && busWdata[DIR_BIT]) ? busWdata[15:0] : 16'd0;
  assign take     = (budget >= BUDGET_W'(4)) ? 3'd4 : budget[2:0];
  assign txAccept = stb.txPush && (take != 3'd0) && !txFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            budget <= '0;
    else if (stb.softRst) budget <= '0;
    else budget <= budget + BUDGET_W'(addBytes) - BUDGET_W'(txAccept ? take : 3'd0);
  end

  i2cq_fifo #(.WIDTH(34), .DEPTH(TX_DEPTH)) u_txq (
    .clk, .rstN, .clr(stb.softRst),
    .push(txAccept), .din({2'(take - 3'd1), busWdata}), .pop(txPopW),
    .dout(txHead), .full(txFull), .empty(txEmpty), .count(txCount)
  );

  assign txValid  = !txEmpty;
  assign txByte   = txHead[{lane, 3'b000} +: 8];
  assign lastLane = (lane == txHead[33:32]);
  assign txPopW   = txValid && txReady && lastLane;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    lane <= '0;
    else if (stb.softRst)         lane <= '0;
    else if (txValid && txReady)  lane <= lastLane ? 2'd0 : lane + 2'd1;
  end

  // receive queue
  logic           rxFull, rxEmpty;
  logic [7:0]     rxHead;
  logic [RCW-1:0] rxCount;

  i2cq_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk, .rstN, .clr(stb.softRst),
    .push(rxValid), .din(rxByte), .pop(stb.rxPop),
    .dout(rxHead), .full(rxFull), .empty(rxEmpty), .count(rxCount)
  );

  // registered read path
  logic [31:0] rdMux;
  always_comb begin
    unique case (stb.rdSel)
      SEL_CFG:   rdMux = {1'b0, cfgReg};
      SEL_IRQ:   rdMux = {16'd0, irqEn, irqStat};
      SEL_QCTL:  rdMux = (32'(runBit) << RUN_BIT) | (32'(pioBit) << PIO_BIT);
      SEL_QSTAT: rdMux = 32'(cmdCount) | (32'(rxEmpty) << RXEMPTY_BIT);
      SEL_RX:    rdMux = rxEmpty ? 32'd0 : {24'd0, rxHead};
      default:   rdMux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busRdata <= '0;
    else if (stb.rdEn) busRdata <= rdMux;
  end

  // R3
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqEvt != 8'd0 && !stb.softRst) |=> ((irqStat & $past(irqEvt)) == $past(irqEvt)));

  // R4
  run_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.qClr && busWdata[RUN_BIT] && !stb.qSet && !stb.qLoad) |=> !cmdValid);

  // R9
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> (cmdCount == '0 && rxEmpty && !txValid && irqStat == 8'd0 && !runBit));

  // R7
  no_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txPush && budget == '0 && !txPopW && !stb.softRst) |=> (txCount == $past(txCount)));
endmodule

// File: rtl/i2cq_regs.sv
module i2cq_regs #(
  parameter int CMD_DEPTH = 16,
  parameter int TX_DEPTH  = 8,
  parameter int RX_DEPTH  = 8,
  parameter int BUDGET_W  = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        cmdValid,
  output logic [31:0] cmdWord,
  input  logic        cmdReady,
  output logic        txValid,
  output logic [7:0]  txByte,
  input  logic        txReady,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic [7:0]  irqEvt,
  output logic        irqOut,
  output logic        pioMode
);
  i2cq_pkg::strobe_t stb;

  i2cq_ctrl u_ctrl (
    .busWrEn, .busRdEn, .busAddr,
    .srstBit(busWdata[i2cq_pkg::SRST_BIT]),
    .stb
  );

  i2cq_datapath #(
    .CMD_DEPTH(CMD_DEPTH), .TX_DEPTH(TX_DEPTH),
    .RX_DEPTH(RX_DEPTH), .BUDGET_W(BUDGET_W)
  ) u_dp (
    .clk, .rstN, .stb, .busWdata, .busRdata,
    .cmdValid, .cmdWord, .cmdReady,
    .txValid, .txByte, .txReady,
    .rxValid, .rxByte, .irqEvt, .irqOut, .pioMode
  );
endmodule

// File: tb/test_i2cq_regs.sv
module test_i2cq_regs;
  logic clk = 1'b0, rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, cmdWord;
  logic cmdValid, cmdReady = 1'b0, txValid, txReady = 1'b0;
  logic [7:0] txByte, rxByte = '0, irqEvt = '0;
  logic rxValid = 1'b0, irqOut, pioMode;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int unsigned seedDummy;

  always #5 clk = ~clk;

  i2cq_regs i_i2cq_regs (
    .clk, .rstN, .busWrEn, .busRdEn, .busAddr, .busWdata, .busRdata,
    .cmdValid, .cmdWord, .cmdReady, .txValid, .txByte, .txReady,
    .rxValid, .rxByte, .irqEvt, .irqOut, .pioMode
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busRdEn = 1'b0;
  endtask

  task automatic takeCmd(output logic [31:0] w);
    w = cmdWord;
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
  endtask

  task automatic takeTx(output logic [7:0] b);
    b = txByte;
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
  endtask

  function automatic logic irqModel(input logic [7:0] s, input logic [7:0] e);
    return |(s & e);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w;
    logic [7:0] b, mStat, mEn;
    logic [7:0] expB [16];
    seedDummy = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, d); chk("R1 cfg", d, 32'h0);
    rd(8'h40, d); chk("R1 irq", d, 32'h0);
    rd(8'h60, d); chk("R1 qctl", d, 32'h0);
    rd(8'h70, d); chk("R1 qstat", d, 32'h2000);
    chk("R1 outputs", {28'd0, irqOut, cmdValid, txValid, pioMode}, 32'h0);

    // R10 load and OR alias, bit 31 reads 0
    wr(8'h00, 32'h0000_1234); rd(8'h00, d); chk("R10 load", d, 32'h1234);
    wr(8'h04, 32'h0005_0000); rd(8'h04, d); chk("R10 set", d, 32'h0005_1234);

    // R11 registered read: old value during the read cycle
    rd(8'h70, d);
    busRdEn = 1'b1; busAddr = 8'h00;
    #2 chk("R11 before edge", busRdata, 32'h2000);
    @(negedge clk); chk("R11 after edge", busRdata, 32'h0005_1234);
    busRdEn = 1'b0;

    // R2 random load/set/clear on the interrupt register, R3 combined output
    mStat = '0; mEn = '0;
    for (int k = 0; k < 40; k++) begin
      int unsigned op;
      logic [31:0] v;
      op = $urandom % 3; v = $urandom;
      case (op)
        0: begin wr(8'h40, v); {mEn, mStat} = v[15:0]; end
        1: begin wr(8'h44, v); {mEn, mStat} = {mEn, mStat} | v[15:0]; end
        default: begin wr(8'h48, v); {mEn, mStat} = {mEn, mStat} & ~v[15:0]; end
      endcase
      chk("R3 irqOut", {31'd0, irqOut}, {31'd0, irqModel(mStat, mEn)});
      rd(8'h40, d); chk("R2 irq reg", d, {16'd0, mEn, mStat});
    end

    // R3 events set sticky status; event beats simultaneous clear
    wr(8'h40, 32'h0000_FF00);
    irqEvt = 8'h24; @(negedge clk); irqEvt = 8'h00;
    chk("R3 evt raises irq", {31'd0, irqOut}, 32'h1);
    irqEvt = 8'h04; wr(8'h48, 32'h0000_0004); irqEvt = 8'h00;
    rd(8'h40, d); chk("R3 evt beats clear", d, 32'h0000_FF24);
    wr(8'h48, 32'h0000_0024);
    chk("R3 cleared", {31'd0, irqOut}, 32'h0);
    wr(8'h40, 32'h0000_0000);
    irqEvt = 8'h81; @(negedge clk); irqEvt = 8'h00;
    chk("R3 masked", {31'd0, irqOut}, 32'h0);
    rd(8'h40, d); chk("R3 masked status", d, 32'h0000_0081);

    // R4 run gating and mode bit
    wr(8'h00, 32'h8000_0000);
    wr(8'h80, 32'h0000_0A01); wr(8'h80, 32'h0000_0A02);
    rd(8'h70, d); chk("R4 count", d, 32'h2002);
    chk("R4 stopped", {31'd0, cmdValid}, 32'h0);
    wr(8'h64, 32'h0000_0020);
    chk("R4 running", {31'd0, cmdValid}, 32'h1);
    wr(8'h68, 32'h0000_0020);
    chk("R4 stop again", {31'd0, cmdValid}, 32'h0);
    wr(8'h60, 32'hFFFF_FFDB);
    chk("R4 pio bit", {31'd0, pioMode}, 32'h0);
    wr(8'h60, 32'h0000_0004);
    chk("R4 pio set", {31'd0, pioMode}, 32'h1);
    wr(8'h64, 32'h0000_0020);
    rd(8'h60, d); chk("R4 qctl readback", d, 32'h24);

    // R5 order, count and full-queue drop
    wr(8'h00, 32'h8000_0000);
    for (int i = 0; i < 18; i++) wr(8'h80, 32'h0000_0100 + i);
    rd(8'h70, d); chk("R5 full count", d, 32'h2010);
    wr(8'h64, 32'h0000_0020);
    for (int i = 0; i < 16; i++) begin
      chk("R5 valid", {31'd0, cmdValid}, 32'h1);
      takeCmd(w); chk("R5 order", w, 32'h0000_0100 + i);
    end
    chk("R5 drained", {31'd0, cmdValid}, 32'h0);

    // R6 byte order, directed
    wr(8'h00, 32'h8000_0000);
    wr(8'h80, 32'h0001_0005);
    wr(8'hA0, 32'h4433_2211); wr(8'hA0, 32'h0000_00AA);
    begin
      logic [7:0] ord [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hAA};
      for (int i = 0; i < 5; i++) begin takeTx(b); chk("R6 byte order", {24'd0, b}, {24'd0, ord[i]}); end
    end
    chk("R6 empty", {31'd0, txValid}, 32'h0);

    // R7 random budgets with a surplus word
    for (int k = 0; k < 20; k++) begin
      int unsigned n, nw;
      wr(8'h00, 32'h8000_0000);
      n = 1 + $urandom % 9;
      nw = (n + 3) / 4 + 1;
      wr(8'h80, 32'h0001_0000 | n);
      for (int j = 0; j < nw; j++) begin
        w = $urandom;
        for (int l = 0; l < 4; l++) if (j * 4 + l < n) expB[j * 4 + l] = w[l * 8 +: 8];
        wr(8'hA0, w);
      end
      for (int i = 0; i < n; i++) begin
        chk("R7 valid", {31'd0, txValid}, 32'h1);
        takeTx(b); chk("R7 byte", {24'd0, b}, {24'd0, expB[i]});
      end
      chk("R7 surplus dropped", {31'd0, txValid}, 32'h0);
    end
    wr(8'h80, 32'h0000_0003);
    wr(8'hA0, 32'h1234_5678);
    chk("R7 read cmd no budget", {31'd0, txValid}, 32'h0);

    // R8 receive queue
    wr(8'h00, 32'h8000_0000);
    for (int i = 0; i < 3; i++) begin
      rxValid = 1'b1; rxByte = 8'hC0 + 8'(i); @(negedge clk);
    end
    rxValid = 1'b0;
    rd(8'h70, d); chk("R8 not empty", d, 32'h0);
    for (int i = 0; i < 3; i++) begin rd(8'h90, d); chk("R8 rx byte", d, 32'hC0 + i); end
    rd(8'h70, d); chk("R8 empty flag", d, 32'h2000);
    rd(8'h90, d); chk("R8 empty read", d, 32'h0);

    // R9 soft reset through the OR alias
    wr(8'h40, 32'h0000_FFFF); wr(8'h64, 32'h0000_0024); wr(8'h00, 32'h0000_0077);
    wr(8'h80, 32'h0001_0004); wr(8'hA0, 32'hDEAD_BEEF);
    rxValid = 1'b1; rxByte = 8'h5A; @(negedge clk); rxValid = 1'b0;
    wr(8'h04, 32'h8000_0001);
    rd(8'h00, d); chk("R9 cfg", d, 32'h0);
    rd(8'h40, d); chk("R9 irq", d, 32'h0);
    rd(8'h60, d); chk("R9 qctl", d, 32'h0);
    rd(8'h70, d); chk("R9 qstat", d, 32'h2000);
    chk("R9 outputs", {29'd0, irqOut, txValid, pioMode}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule